// File: doc/BRIEF.md
# Fractional-Second Timestamp Counter with Wakeup Alarm

This block keeps a free-running, monotonic 48-bit timestamp for low-power scheduling. The count is a binary fixed-point number of seconds. The top 32 bits hold whole seconds and the bottom 16 bits hold 1/65536 fractions of a second. A one-cycle enable at 65,536 Hz advances the count. Software cannot rewrite the count once it runs. The only exception is a single load after reset, which sets the starting value.

To schedule an event, software computes the future count value. It writes the low 24 bits of that value into the compare register and then sleeps. When a tick brings the low slice of the count to that value, a sticky wakeup flag rises. A second sticky flag records that the full count has wrapped to zero.

The count is read as a 32-bit low word and a 16-bit high word. A read strobe on the low word captures the high bits of that same cycle. The pair therefore stays coherent even if a tick lands between the two accesses.

Top module: `fracsec_timer`

## Requirements
- R1: In a cycle with tick_i high and no accepted load, the 48-bit count advances by one at the next edge; otherwise it holds. Bits [15:0] are the fraction and bits [47:16] are seconds, so a fraction of 0xFFFF carries into the seconds.
- R2: While rst_ni is low, the count, the compare value, the high-word snapshot and both flags are all zero, and the one-time load is re-armed.
- R3: The first cycle with init_i high after reset loads init_val_i into the count. Any later init_i is ignored until the next reset.
- R4: A tick at count 0xFFFF_FFFF_FFFF wraps the count to zero and sets ovf_o at the same edge. ovf_o stays set until a cycle with clr_ovf_i and no new wrap; a wrap in the clearing cycle keeps it set.
- R5: A tick that makes count[23:0] equal the compare value sets match_o at the edge where the count takes that value. match_o stays set until clr_match_i; a new hit in the clearing cycle keeps it set.
- R6: match_o is set only by the tick that reaches the compare value. A count that rests on that value, or that is loaded to it, does not set the flag again after a clear.
- R7: A compare write takes effect at the next edge. A tick in the write cycle does not set match_o, whether it reaches the old or the new compare value.
- R8: In a cycle with rd_lo_i high, cnt_hi_o captures count[47:32] of that cycle at the next edge, paired with the cnt_lo_o value shown in that cycle. Otherwise cnt_hi_o holds.
- R9: When an accepted load and a tick come in the same cycle, the load wins and the loaded value is not incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one pulse per 1/65536 s |
| init_i | input | 1 | One-time load strobe |
| init_val_i | input | 48 | Start value for the one-time load |
| cmp_we_i | input | 1 | Compare register write strobe |
| cmp_val_i | input | 24 | New compare value for count[23:0] |
| clr_ovf_i | input | 1 | Clear the wrap flag |
| clr_match_i | input | 1 | Clear the wakeup flag |
| rd_lo_i | input | 1 | Low-word read strobe; latches the high word |
| cnt_lo_o | output | 32 | Live count[31:0] |
| cnt_hi_o | output | 16 | count[47:32] captured at the last low-word read |
| ovf_o | output | 1 | Sticky wrap flag |
| match_o | output | 1 | Sticky wakeup flag |

## Verification
Every output is a register, so each stimulus shows its result exactly one edge later. A tick, load, wrap, hit or high-word capture driven in one cycle appears on the ports after the following rising edge. The bench drives inputs on the falling edge, advances its behavioural model on the rising edge, and compares all four outputs at the next falling edge. Directed checks are placed on that same one-edge delay: the last tick before a hit, the write-cycle suppression, the set-versus-clear collisions, the load-and-tick collision and the full wrap.

// File: rtl/fracsec_pkg.sv
package fracsec_pkg;
  localparam int unsigned SEC_W  = 32;
  localparam int unsigned FRAC_W = 16;
  localparam int unsigned CMP_W  = 24;
  localparam int unsigned WORD_W = 32;

  // sticky flag: a new event beats a clear in the same cycle
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/fracsec_counter.sv
module fracsec_counter
  import fracsec_pkg::*;
#(
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             init_i,
  input  logic [CNT_W-1:0] init_val_i,
  input  logic             clr_ovf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             step_o,
  output logic             init_done_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             init_done_q, ovf_q;
  logic             load, step, wrap;

  assign load = init_i & ~init_done_q;
  assign step = tick_i & ~load;
  assign wrap = step & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      init_done_q <= 1'b0;
      ovf_q       <= 1'b0;
    end else begin
      if (load)      cnt_q <= init_val_i;
      else if (step) cnt_q <= nxt_o;
      if (load) init_done_q <= 1'b1;
      ovf_q <= sticky_next(ovf_q, wrap, clr_ovf_i);
    end
  end

  assign nxt_o       = cnt_q + CNT_W'(1);
  assign cnt_o       = cnt_q;
  assign step_o      = step;
  assign init_done_o = init_done_q;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/fracsec_alarm.sv
module fracsec_alarm
  import fracsec_pkg::*;
#(
  parameter int unsigned CW = CMP_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [CW-1:0] nxt_low_i,
  input  logic          cmp_we_i,
  input  logic [CW-1:0] cmp_val_i,
  input  logic          clr_match_i,
  output logic          match_o
);
  logic [CW-1:0] cmp_q;
  logic          match_q, hit;

  // write cycle masks the hit against both old and new value
  assign hit = step_i & ~cmp_we_i & (nxt_low_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q   <= '0;
      match_q <= 1'b0;
    end else begin
      if (cmp_we_i) cmp_q <= cmp_val_i;
      match_q <= sticky_next(match_q, hit, clr_match_i);
    end
  end

  assign match_o = match_q;
endmodule

// File: rtl/fracsec_snapshot.sv
module fracsec_snapshot #(
  parameter int unsigned HW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [HW-1:0] hi_i,
  output logic [HW-1:0] hi_o
);
  logic [HW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hi_q <= '0;
    else if (rd_i) hi_q <= hi_i;
  end

  assign hi_o = hi_q;
endmodule

// File: rtl/fracsec_timer.sv
module fracsec_timer
  import fracsec_pkg::*;
#(
  parameter int unsigned SW    = SEC_W,
  parameter int unsigned FW    = FRAC_W,
  parameter int unsigned CW    = CMP_W,
  parameter int unsigned LW    = WORD_W,
  localparam int unsigned CNT_W = SW + FW,
  localparam int unsigned HI_W  = CNT_W - LW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             init_i,
  input  logic [CNT_W-1:0] init_val_i,
  input  logic             cmp_we_i,
  input  logic [CW-1:0]    cmp_val_i,
  input  logic             clr_ovf_i,
  input  logic             clr_match_i,
  input  logic             rd_lo_i,
  output logic [LW-1:0]    cnt_lo_o,
  output logic [HI_W-1:0]  cnt_hi_o,
  output logic             ovf_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             step, init_done_q;

  fracsec_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i, .rst_ni, .tick_i, .init_i, .init_val_i, .clr_ovf_i,
    .cnt_o(cnt_q), .nxt_o(cnt_nxt), .step_o(step),
    .init_done_o(init_done_q), .ovf_o(ovf_o)
  );

  fracsec_alarm #(.CW(CW)) i_alarm (
    .clk_i, .rst_ni, .step_i(step), .nxt_low_i(cnt_nxt[CW-1:0]),
    .cmp_we_i, .cmp_val_i, .clr_match_i, .match_o(match_o)
  );

  fracsec_snapshot #(.HW(HI_W)) i_snapshot (
    .clk_i, .rst_ni, .rd_i(rd_lo_i), .hi_i(cnt_q[CNT_W-1:LW]), .hi_o(cnt_hi_o)
  );

  assign cnt_lo_o = cnt_q[LW-1:0];
endmodule

// File: rtl/fracsec_timer_chk.sv
module fracsec_timer_chk #(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned HI_W  = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             init_i,
  input logic             rd_lo_i,
  input logic             cmp_we_i,
  input logic             clr_ovf_i,
  input logic             clr_match_i,
  input logic             ovf_o,
  input logic             match_o,
  input logic [HI_W-1:0]  cnt_hi_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             init_done_q
);
  // R1
  tick_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && init_done_q |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && (!init_i || init_done_q) |=> $stable(cnt_q));
  // R3
  init_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_q |=> init_done_q);
  // R4
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !clr_ovf_i |=> ovf_o);
  // R4
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(tick_i) && $past(&cnt_q) && cnt_q == '0);
  // R5
  match_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o && !clr_match_i |=> match_o);
  // R7
  match_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> $past(tick_i) && !$past(cmp_we_i));
  // R8
  hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_lo_i |=> $stable(cnt_hi_o));
endmodule

bind fracsec_timer fracsec_timer_chk #(.CNT_W(CNT_W), .HI_W(HI_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .init_i(init_i),
  .rd_lo_i(rd_lo_i), .cmp_we_i(cmp_we_i), .clr_ovf_i(clr_ovf_i),
  .clr_match_i(clr_match_i), .ovf_o(ovf_o), .match_o(match_o),
  .cnt_hi_o(cnt_hi_o), .cnt_q(cnt_q), .init_done_q(init_done_q)
);

// File: tb/test_fracsec_timer.sv
module test_fracsec_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, init = 1'b0, cmp_we = 1'b0;
  logic        clr_ovf = 1'b0, clr_match = 1'b0, rd_lo = 1'b0;
  logic [47:0] init_val = '0;
  logic [23:0] cmp_val = '0;
  logic [31:0] cnt_lo;
  logic [15:0] cnt_hi;
  logic        ovf, match;

  int total = 0, bad = 0, cycles = 0;
  bit done = 1'b0;

  always #5ns clk = ~clk;

  fracsec_timer i_fracsec_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .init_i(init), .init_val_i(init_val),
    .cmp_we_i(cmp_we), .cmp_val_i(cmp_val), .clr_ovf_i(clr_ovf),
    .clr_match_i(clr_match), .rd_lo_i(rd_lo), .cnt_lo_o(cnt_lo),
    .cnt_hi_o(cnt_hi), .ovf_o(ovf), .match_o(match)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [47:0] m_cnt;
  logic [23:0] m_cmp;
  logic [15:0] m_hi;
  bit          m_loaded, m_ovf, m_match;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_cmp = '0; m_hi = '0;
      m_loaded = 0; m_ovf = 0; m_match = 0;
    end else begin
      bit wrapped, hit;
      wrapped = 0; hit = 0;
      if (rd_lo) m_hi = m_cnt[47:32];
      if (init && !m_loaded) begin
        m_cnt = init_val; m_loaded = 1;
      end else if (tick) begin
        wrapped = (m_cnt == 48'hFFFF_FFFF_FFFF);
        m_cnt = m_cnt + 48'd1;
        hit = !cmp_we && (m_cnt[23:0] == m_cmp);
      end
      if (cmp_we) m_cmp = cmp_val;
      m_ovf   = wrapped || (m_ovf && !clr_ovf);
      m_match = hit || (m_match && !clr_match);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 cnt_lo", cnt_lo, m_cnt[31:0]);
      check("R8 cnt_hi", cnt_hi, m_hi);
      check("R4 ovf", ovf, m_ovf);
      check("R5 match", match, m_match);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1; cyc(n); tick = 1'b0;
  endtask

  initial begin
    cyc(2);
    // R2 reset state
    check("R2 lo", cnt_lo, 0); check("R2 hi", cnt_hi, 0);
    check("R2 ovf", ovf, 0);   check("R2 match", match, 0);
    do_reset();

    // R3 first load accepted
    init = 1; init_val = 48'h5A5A_0001_FFF0; cyc(1); init = 0;
    check("R3 load", cnt_lo, 32'h0001_FFF0);
    // R3 second load ignored
    init = 1; init_val = 48'h1111_2222_3333; cyc(1); init = 0; cyc(1);
    check("R3 ignore", cnt_lo, 32'h0001_FFF0);
    // R1 fraction carries into seconds
    ticks(16);
    check("R1 carry", cnt_lo, 32'h0002_0000);

    // R8 coherent high word
    check("R8 before", cnt_hi, 0);
    rd_lo = 1; cyc(1); rd_lo = 0;
    check("R8 capture", cnt_hi, 16'h5A5A);

    // R5 hit on exact tick
    cmp_we = 1; cmp_val = 24'h020005; cyc(1); cmp_we = 0;
    ticks(4);
    check("R5 pre", match, 0);
    ticks(1);
    check("R5 hit", match, 1);
    cyc(3);
    check("R5 sticky", match, 1);
    // R6 resting on the value does not re-set
    clr_match = 1; cyc(1); clr_match = 0; cyc(2);
    check("R6 no reset", match, 0);

    // R5 set beats clear
    cmp_we = 1; cmp_val = 24'h02000A; cyc(1); cmp_we = 0;
    ticks(4);
    check("R5 pre2", match, 0);
    tick = 1; clr_match = 1; cyc(1); tick = 0; clr_match = 0;
    check("R5 set wins", match, 1);

    // R7 write cycle masks the new value
    clr_match = 1; cyc(1); clr_match = 0;
    tick = 1; cmp_we = 1; cmp_val = 24'h02000B; cyc(1); tick = 0; cmp_we = 0;
    check("R7 cnt", cnt_lo, 32'h0002_000B);
    check("R7 new masked", match, 0);
    // R7 write cycle masks the old value
    cmp_we = 1; cmp_val = 24'h02000D; cyc(1); cmp_we = 0;
    ticks(1);
    tick = 1; cmp_we = 1; cmp_val = 24'h000100; cyc(1); tick = 0; cmp_we = 0;
    check("R7 old masked", match, 0);

    // R9 load and tick together; R4 wrap
    do_reset();
    check("R2 lo again", cnt_lo, 0);
    init = 1; tick = 1; init_val = 48'hFFFF_FFFF_FFFE; cyc(1); init = 0; tick = 0;
    check("R9 load wins", cnt_lo, 32'hFFFF_FFFE);
    ticks(1);
    check("R4 pre", ovf, 0);
    rd_lo = 1; cyc(1); rd_lo = 0;
    check("R8 hi max", cnt_hi, 16'hFFFF);
    ticks(1);
    check("R4 wrap cnt", cnt_lo, 0);
    check("R4 wrap flag", ovf, 1);
    ticks(3);
    check("R4 sticky", ovf, 1);
    clr_ovf = 1; cyc(1); clr_ovf = 0;
    check("R4 clear", ovf, 0);
    rd_lo = 1; cyc(1); rd_lo = 0;
    check("R8 hi wrapped", cnt_hi, 0);

    cyc(2);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule